// File: doc/BRIEF.md
# Converter Sample Offset and Over-Range Stage

This block sits behind a two-channel 14-bit converter and post-processes each channel's sample stream on its own. Every sample word is a 14-bit two's-complement code with a valid strobe. A signed correction set by a small configuration field is added to each code, and the sum is held at the 14-bit signed limits instead of wrapping. The corrected sample comes out a fixed 31 clock cycles after it went in.

Each channel has one over-range pin, and that pin has two sources. In the normal source, the flag marks samples whose raw code sat at either extreme of the 14-bit range. It travels down the same 31-cycle pipeline as the data, so it lines up with the corrected sample it belongs to. A per-channel enable switches the pin to a fast source that reports four cycles after the sample. The fast source compares the absolute value of the raw sample against one of eight thresholds set below full scale. Each channel has its own offset, enable and threshold fields.

Top module: `adc_post_proc`

## Requirements
- R1: While reset is asserted and right after it, every output (corrected samples, valid strobes, over-range pins) is zero.
- R2: The corrected sample equals the raw sample plus the offset field, read as 6-bit two's complement (6'b100000 = -32 up to 6'b011111 = +31). It appears on the output, with the output valid copying the input valid, exactly 31 clock edges after the edge that captured the input.
- R3: A sum above +8191 is output as 14'h1FFF. A sum below -8192 is output as 14'h2000. Sums that land exactly on a limit pass through unchanged.
- R4: With the offset field at 6'b000000, the corrected sample equals the raw sample.
- R5: When fast mode is off, the over-range pin is 1 exactly for valid samples whose raw code is 14'h1FFF or 14'h2000, whatever the offset. It appears in the same cycle as that sample's corrected output, 31 edges after capture.
- R6: When fast mode is on, the over-range pin reports |raw| >= threshold for valid samples, 4 clock edges after capture. Invalid samples never raise it.
- R7: The 3-bit threshold select maps codes 0 to 7 to magnitudes 1024, 1536, 2048, 3072, 4096, 5120, 6144 and 7168, which are 2, 3, 4, 6, 8, 10, 12 and 14 sixteenths of 8192.
- R8: A sample with its valid strobe low produces valid 0 and over-range 0 at the output, while its data still passes through the pipeline.
- R9: The two channels are independent. Each uses only its own offset, fast enable and threshold select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 2 | Per-channel sample strobe |
| in_sample | input | 2x14 | Raw two's-complement samples, channel 0 in the low word |
| cfg_offset | input | 2x6 | Per-channel signed offset |
| cfg_fast_en | input | 2 | Per-channel fast over-range select |
| cfg_thr_sel | input | 2x3 | Per-channel fast threshold code |
| out_valid | output | 2 | Valid delayed by 31 cycles |
| out_sample | output | 2x14 | Corrected, clamped samples |
| out_ovr | output | 2 | Over-range pin per channel |

## Verification
The bench drives positive and negative sums that overshoot the limits by one and by many codes, along with sums that land exactly on a limit. A design that wraps, or that clamps one step early, shows up as a wrong code. It also puts extreme raw codes under offsets that pull them back inside the range. A design that derived the flag from the corrected sum would then drop it. For each threshold code, the fast path gets magnitudes one below and exactly at the threshold, with both signs. An off-by-one comparison, a wrong table entry or a bad absolute value at -8192 shows up as a missing or spurious flag. The two channels run different settings at the same time, and the bench counts the exact output cycle for both paths, so a shared configuration or a pipeline one stage too long or too short fails.

// File: rtl/adc_post_pkg.sv
package adc_post_pkg;

    localparam int THR_SEL_W = 3;

    typedef logic [THR_SEL_W-1:0] thr_sel_t;

    // Threshold as a count of sixteenths of full-scale magnitude.
    function automatic logic [3:0] thr_frac16(input thr_sel_t sel);
        logic [3:0] f;
        case (sel)
            3'd0:    f = 4'd2;
            3'd1:    f = 4'd3;
            3'd2:    f = 4'd4;
            3'd3:    f = 4'd6;
            3'd4:    f = 4'd8;
            3'd5:    f = 4'd10;
            3'd6:    f = 4'd12;
            default: f = 4'd14;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/delay_line.sv
module delay_line #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef logic [WIDTH-1:0] word_t;

    word_t pipe_d [DEPTH];
    word_t pipe_q [DEPTH];

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pipe_q[i] <= '0;
            end
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[DEPTH-1];

endmodule

// File: rtl/offset_clamp.sv
module offset_clamp #(
    parameter int DW = 14,
    parameter int OW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_sample,
    input  logic [OW-1:0] offset,
    output logic          out_valid,
    output logic          out_ovr,
    output logic [DW-1:0] out_sample
);
    localparam logic [DW-1:0] MAX_CODE = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MIN_CODE = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW:0] SUM_MAX = {2'b00, {(DW-1){1'b1}}};
    localparam logic signed [DW:0] SUM_MIN = {2'b11, {(DW-1){1'b0}}};

    typedef struct packed {
        logic          vld;
        logic          ovr;
        logic [DW-1:0] data;
    } stage_t;

    stage_t st_d, st_q;
    logic signed [DW:0] sum_w;

    always_comb begin
        sum_w = {in_sample[DW-1], in_sample}
              + {{(DW+1-OW){offset[OW-1]}}, offset};
        st_d.vld = in_valid;
        st_d.ovr = in_valid && ((in_sample == MAX_CODE) || (in_sample == MIN_CODE));
        if (sum_w > SUM_MAX) begin
            st_d.data = MAX_CODE;
        end else if (sum_w < SUM_MIN) begin
            st_d.data = MIN_CODE;
        end else begin
            st_d.data = sum_w[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign out_ovr    = st_q.ovr;
    assign out_sample = st_q.data;

    // Marks that one edge has passed since reset, so $past is meaningful.
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    p_zero_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(offset) == '0) |-> (st_q.data == $past(in_sample)));

    p_sat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(in_sample) == MAX_CODE && !$past(offset[OW-1]))
        |-> (st_q.data == MAX_CODE));

    p_sat_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(in_sample) == MIN_CODE && $past(offset[OW-1]))
        |-> (st_q.data == MIN_CODE));

    p_ext_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(in_valid) && $past(in_sample) == MAX_CODE) |-> st_q.ovr);

endmodule

// File: rtl/fast_range_detect.sv
module fast_range_detect
    import adc_post_pkg::*;
#(
    parameter int DW       = 14,
    parameter int FAST_LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_sample,
    input  thr_sel_t      thr_sel,
    output logic          hit
);
    localparam int TAIL = FAST_LAT - 2;
    localparam logic [DW:0] MIN_THR = (DW+1)'(2) << (DW-5);

    typedef struct packed {
        logic          vld;
        logic [DW:0]   mag;
        logic          hit;
    } stage_t;

    stage_t st_d, st_q;
    logic [DW:0] thr_w;

    always_comb begin
        thr_w    = {{(DW+1-4){1'b0}}, thr_frac16(thr_sel)} << (DW-5);
        st_d.vld = in_valid;
        st_d.mag = in_sample[DW-1] ? (~{1'b1, in_sample} + 1'b1) : {1'b0, in_sample};
        st_d.hit = st_q.vld && (st_q.mag >= thr_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    delay_line #(.WIDTH(1), .DEPTH(TAIL)) i_tail (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (st_q.hit),
        .dout (hit)
    );

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    p_fast_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && st_q.hit) |-> ($past(st_q.mag) >= MIN_THR));

    p_fast_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && st_q.hit) |-> $past(st_q.vld));

endmodule

// File: rtl/adc_post_proc.sv
module adc_post_proc
    import adc_post_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int DW       = 14,
    parameter int OW       = 6,
    parameter int STD_LAT  = 31,
    parameter int FAST_LAT = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCH-1:0]               in_valid,
    input  logic [NCH-1:0][DW-1:0]       in_sample,
    input  logic [NCH-1:0][OW-1:0]       cfg_offset,
    input  logic [NCH-1:0]               cfg_fast_en,
    input  logic [NCH-1:0][THR_SEL_W-1:0] cfg_thr_sel,
    output logic [NCH-1:0]               out_valid,
    output logic [NCH-1:0][DW-1:0]       out_sample,
    output logic [NCH-1:0]               out_ovr
);
    localparam int STD_TAIL = STD_LAT - 1;
    localparam int PW       = DW + 2;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic          s1_vld, s1_ovr, fast_hit;
        logic [DW-1:0] s1_data;
        logic [PW-1:0] tail_out;

        offset_clamp #(.DW(DW), .OW(OW)) i_clamp (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid[c]),
            .in_sample (in_sample[c]),
            .offset    (cfg_offset[c]),
            .out_valid (s1_vld),
            .out_ovr   (s1_ovr),
            .out_sample(s1_data)
        );

        delay_line #(.WIDTH(PW), .DEPTH(STD_TAIL)) i_align (
            .clk  (clk),
            .rst_n(rst_n),
            .din  ({s1_vld, s1_ovr, s1_data}),
            .dout (tail_out)
        );

        fast_range_detect #(.DW(DW), .FAST_LAT(FAST_LAT)) i_fast (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid[c]),
            .in_sample(in_sample[c]),
            .thr_sel  (cfg_thr_sel[c]),
            .hit      (fast_hit)
        );

        always_comb begin
            out_valid[c]  = tail_out[PW-1];
            out_sample[c] = tail_out[DW-1:0];
            out_ovr[c]    = cfg_fast_en[c] ? fast_hit : tail_out[DW];
        end

        p_std_flag_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_fast_en[c] && out_ovr[c]) |-> out_valid[c]);
    end

endmodule

// File: tb/test_adc_post_proc.sv
module test_adc_post_proc;

    localparam int NV = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      in_valid = '0;
    logic [1:0][13:0] in_sample = '0;
    logic [1:0][5:0] cfg_offset = '0;
    logic [1:0]      cfg_fast_en = '0;
    logic [1:0][2:0] cfg_thr_sel = '0;
    logic [1:0]      out_valid;
    logic [1:0][13:0] out_sample;
    logic [1:0]      out_ovr;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    adc_post_proc i_adc_post_proc (
        .clk, .rst_n, .in_valid, .in_sample, .cfg_offset,
        .cfg_fast_en, .cfg_thr_sel, .out_valid, .out_sample, .out_ovr
    );

    localparam logic [13:0] T_RAW0 [NV] = '{
        14'sd100, 14'sd100, 14'sd8191, 14'sd8190, 14'sd8191, 14'sd8191, 14'sd0,
        -14'sd1, 14'sd5000, -14'sd8160, 14'sd1234, 14'sd7168, 14'sd1023, 14'sd3072};
    localparam logic [13:0] T_RAW1 [NV] = '{
        -14'sd100, 14'sd200, -14'sd8192, -14'sd8190, -14'sd8192, -14'sd8192, 14'sd0,
        14'sd8160, -14'sd5000, 14'sd1, 14'sd8191, -14'sd7168, -14'sd1024, -14'sd3071};
    localparam logic [5:0] T_OFF0 [NV] = '{
        6'h00, 6'h1F, 6'h01, 6'h05, 6'h20, 6'h00, 6'h3F,
        6'h20, 6'h00, 6'h20, 6'h03, 6'h00, 6'h00, 6'h00};
    localparam logic [5:0] T_OFF1 [NV] = '{
        6'h00, 6'h20, 6'h3F, 6'h20, 6'h1F, 6'h00, 6'h01,
        6'h1F, 6'h00, 6'h3F, 6'h00, 6'h00, 6'h00, 6'h00};
    localparam logic [1:0] T_VLD [NV] = '{
        2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11,
        2'b11, 2'b11, 2'b11, 2'b01, 2'b11, 2'b11, 2'b11};

    function automatic logic [13:0] exp_data(logic [13:0] raw, logic [5:0] off);
        int s;
        s = int'($signed(raw)) + int'($signed(off));
        if (s > 8191)  s = 8191;
        if (s < -8192) s = -8192;
        return s[13:0];
    endfunction

    function automatic logic exp_std(logic [13:0] raw, logic v);
        return v && (raw == 14'h1FFF || raw == 14'h2000);
    endfunction

    function automatic int thr_of(logic [2:0] sel);
        case (sel)
            3'd0: return 1024;  3'd1: return 1536;
            3'd2: return 2048;  3'd3: return 3072;
            3'd4: return 4096;  3'd5: return 5120;
            3'd6: return 6144;  default: return 7168;
        endcase
    endfunction

    function automatic logic exp_fast(logic [13:0] raw, logic v, logic [2:0] sel);
        int m;
        m = int'($signed(raw));
        if (m < 0) m = -m;
        return v && (m >= thr_of(sel));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_vec(int i);
        in_valid      = T_VLD[i];
        in_sample[0]  = T_RAW0[i];
        in_sample[1]  = T_RAW1[i];
        cfg_offset[0] = T_OFF0[i];
        cfg_offset[1] = T_OFF1[i];
    endtask

    task automatic drive_idle();
        in_valid   = '0;
        in_sample  = '0;
        cfg_offset = '0;
    endtask

    // Streams the table; output at negedge c belongs to the input driven at negedge c-31.
    task automatic run_table(logic fast);
        for (int c = 0; c < NV + 31; c++) begin
            @(negedge clk);
            if (c >= 31) begin
                int k = c - 31;
                chk("R2 data ch0", 32'(out_sample[0]), 32'(exp_data(T_RAW0[k], T_OFF0[k])));
                chk("R3 data ch1", 32'(out_sample[1]), 32'(exp_data(T_RAW1[k], T_OFF1[k])));
                chk("R8 valid", 32'(out_valid), 32'(T_VLD[k]));
                if (!fast) begin
                    chk("R5 std flag ch0", 32'(out_ovr[0]), 32'(exp_std(T_RAW0[k], T_VLD[k][0])));
                    chk("R5 std flag ch1", 32'(out_ovr[1]), 32'(exp_std(T_RAW1[k], T_VLD[k][1])));
                end
            end
            if (fast && c >= 4 && c - 4 < NV) begin
                int k = c - 4;
                chk("R6 fast ch0", 32'(out_ovr[0]), 32'(exp_fast(T_RAW0[k], T_VLD[k][0], cfg_thr_sel[0])));
                chk("R9 fast ch1", 32'(out_ovr[1]), 32'(exp_fast(T_RAW1[k], T_VLD[k][1], cfg_thr_sel[1])));
            end
            if (c < NV) drive_vec(c);
            else        drive_idle();
        end
    endtask

    // Drives one sample pair, then idles; checks both fast flags 4 edges later.
    task automatic fast_probe(logic [13:0] r0, logic [13:0] r1);
        @(negedge clk);
        in_valid = 2'b11; in_sample[0] = r0; in_sample[1] = r1;
        @(negedge clk);
        drive_idle();
        repeat (3) @(negedge clk);
        chk("R7 thr ch0", 32'(out_ovr[0]), 32'(exp_fast(r0, 1'b1, cfg_thr_sel[0])));
        chk("R7 thr ch1", 32'(out_ovr[1]), 32'(exp_fast(r1, 1'b1, cfg_thr_sel[1])));
    endtask

    initial begin
        #(20ns * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(out_valid), 0);
        chk("R1 reset data", 32'(out_sample), 0);
        chk("R1 reset ovr", 32'(out_ovr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {out_valid, out_ovr, out_sample}, 0);

        // Standard mode: data, valid, extreme-code flag.
        run_table(1'b0);

        // Fast mode with different thresholds per channel.
        cfg_fast_en = 2'b11;
        cfg_thr_sel[0] = 3'd3;
        cfg_thr_sel[1] = 3'd7;
        run_table(1'b1);

        // Threshold sweep: one below and exactly at each level, both signs.
        for (int s = 0; s < 8; s++) begin
            int t = thr_of(3'(s));
            cfg_thr_sel[0] = 3'(s);
            cfg_thr_sel[1] = 3'(s);
            fast_probe(14'(t), 14'(-(t - 1)));
            fast_probe(14'(t - 1), 14'(-t));
        end
        cfg_thr_sel[0] = 3'd7;
        fast_probe(14'h2000, 14'h1FFF);

        // R9: ch0 fast, ch1 standard, same extreme sample.
        repeat (32) @(negedge clk);
        cfg_fast_en = 2'b01;
        cfg_thr_sel = '0;
        in_valid = 2'b11; in_sample[0] = 14'h1FFF; in_sample[1] = 14'h1FFF;
        @(negedge clk);
        drive_idle();
        repeat (3) @(negedge clk);
        chk("R9 ch0 fast flag", 32'(out_ovr[0]), 1);
        chk("R9 ch1 std flag early", 32'(out_ovr[1]), 0);
        repeat (27) @(negedge clk);
        chk("R9 ch1 std flag at 31", 32'(out_ovr[1]), 1);
        chk("R4 zero offset ch1", 32'(out_sample[1]), 32'h1FFF);
        @(negedge clk);
        chk("R5 flag one cycle only", 32'(out_ovr[1]), 0);

        // Mid-run reset clears every output.
        in_valid = 2'b11; in_sample[0] = 14'h1FFF; in_sample[1] = 14'h2000;
        repeat (35) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 mid reset", {out_valid, out_ovr, out_sample}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule